// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

The block keeps every in-flight instruction of an out-of-order core in program order inside a ring of slots. Decode writes up to two new instructions per cycle at the tail. Each one carries an architectural destination, the renamed physical destination, a store flag and its program counter, and decode receives the slot tag back in the same cycle. Execution units report completion against a tag in any order, and a report may carry an exception flag. A completed result stays speculative until its slot becomes the oldest.

Each cycle the block scans forward from the head. It retires up to four consecutive completed slots and stops at the first slot that is not complete. Every retired slot publishes an architectural-to-physical register pairing on its commit lane. A retired store also raises a release strobe for the store buffer. An exception is raised only when its slot retires. The faulting slot commits nothing, and every younger slot is discarded, so the ring is empty in the next cycle. Decode is held off through the ready output while fewer slots are free than one allocation group needs.

Top module: `rob_core`

## Requirements
- R1: Accepted allocation lanes take consecutive slots in ring order starting at the tail. Lane k receives, on alloc_tag_o in the same cycle, the tail index plus the number of accepted lanes below k. The tag is the slot index 0..DEPTH-1, and the first tag after reset is 0.
- R2: alloc_ready_o is high exactly when at least ALLOC_W slots are free. Requests presented while it is low, or in a cycle that raises an exception, are dropped.
- R3: A completion report marks its slot complete but causes no commit, store release or exception by itself.
- R4: Retirement starts at the head and follows program order. It covers at most RETIRE_W slots per cycle, all consecutive and complete. A complete younger slot waits while an older one is incomplete.
- R5: Commit lane k carries the architectural and physical destination of the k-th slot retiring in that cycle. The outputs are valid in the cycle after the completion that unblocked the slot.
- R6: A retiring store without an exception raises store_rel_o on its commit lane for exactly one cycle. Non-stores never raise it.
- R7: With DEPTH slots occupied, no further slot is accepted. The occupancy never exceeds DEPTH, and every accepted instruction retires exactly once.
- R8: An exception raises exc_valid_o for one cycle, with that slot's program counter on exc_pc_o, when the slot retires. It does not fire at completion. The faulting slot raises no commit and no store release, while older slots retiring in the same cycle commit normally.
- R9: After an exception the ring is empty in the next cycle and younger slots never commit. The next allocated tag is the slot after the faulting one.
- R10: A completion report for a slot that holds no instruction is ignored, including its exception flag.
- R11: Allocation, completion and retirement in the same cycle keep the occupancy consistent. No live slot is overwritten, and the commit stream is exactly the accepted stream in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | ALLOC_W | Allocation request per lane |
| alloc_areg_i | input | ALLOC_W x AREG_W | Architectural destination per lane |
| alloc_preg_i | input | ALLOC_W x PREG_W | Physical destination per lane |
| alloc_store_i | input | ALLOC_W | Store flag per lane |
| alloc_pc_i | input | ALLOC_W x PC_W | Program counter per lane |
| alloc_ready_o | output | 1 | At least ALLOC_W slots free |
| alloc_tag_o | output | ALLOC_W x IDX_W | Slot tag assigned per lane |
| cmp_valid_i | input | CMP_W | Completion report per port |
| cmp_tag_i | input | CMP_W x IDX_W | Slot tag of the report |
| cmp_exc_i | input | CMP_W | Exception flag of the report |
| commit_valid_o | output | RETIRE_W | Register commit per lane |
| commit_areg_o | output | RETIRE_W x AREG_W | Committed architectural destination |
| commit_preg_o | output | RETIRE_W x PREG_W | Committed physical destination |
| store_rel_o | output | RETIRE_W | Store release strobe per lane |
| exc_valid_o | output | 1 | Exception retires this cycle |
| exc_pc_o | output | PC_W | Program counter of the faulting slot |

## Verification
The assertions assume that a completion tag names the instruction currently in that slot. They also assume that no unit reports on a tag after that tag has retired and been handed out again. The stimulus only completes tags that decode received back, except in the deliberate stray-report test, which targets a free slot. Decode requests are never driven in a cycle where the bench expects an exception. The streaming test gates its requests on the ready output, so no request is knowingly dropped there.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
  localparam int unsigned AREG_W = 5;
  localparam int unsigned PREG_W = 7;
  localparam int unsigned PC_W   = 32;

  typedef struct packed {
    logic              st;
    logic [AREG_W-1:0] areg;
    logic [PREG_W-1:0] preg;
    logic [PC_W-1:0]   pc;
  } rob_meta_t;
endpackage

// File: rtl/rob_alloc.sv
`timescale 1ns/1ps
module rob_alloc #(
  parameter  int unsigned DEPTH   = 16,
  parameter  int unsigned ALLOC_W = 2,
  localparam int unsigned IDX_W   = $clog2(DEPTH),
  localparam int unsigned PTR_W   = IDX_W + 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ALLOC_W-1:0]              req_i,
  input  logic                            flush_i,
  input  logic [PTR_W-1:0]                head_i,
  input  logic [PTR_W-1:0]                head_nxt_i,
  output logic                            ready_o,
  output logic [ALLOC_W-1:0]              fire_o,
  output logic [ALLOC_W-1:0][IDX_W-1:0]   slot_o
);
  logic [PTR_W-1:0] tail_q, tail_d, occ, n_acc;
  logic [PTR_W:0]   free;
  logic             full, empty;

  assign occ     = tail_q - head_i;
  assign free    = (PTR_W+1)'(DEPTH) - {1'b0, occ};
  assign ready_o = free >= (PTR_W+1)'(ALLOC_W);
  assign full    = (tail_q[IDX_W-1:0] == head_i[IDX_W-1:0]) && (tail_q[IDX_W] != head_i[IDX_W]);
  assign empty   = (tail_q == head_i);

  always_comb begin
    n_acc = '0;
    for (int k = 0; k < ALLOC_W; k++) begin
      fire_o[k] = req_i[k] & ready_o & ~flush_i;
      slot_o[k] = IDX_W'(tail_q + n_acc);
      n_acc     = n_acc + PTR_W'(fire_o[k]);
    end
    tail_d = flush_i ? head_nxt_i : tail_q + n_acc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tail_q <= '0;
    else         tail_q <= tail_d;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= PTR_W'(DEPTH)); // R7
  AST_FULL_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> (!ready_o && fire_o == '0)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty); // R9
endmodule

// File: rtl/rob_state.sv
`timescale 1ns/1ps
module rob_state #(
  parameter  int unsigned DEPTH    = 16,
  parameter  int unsigned ALLOC_W  = 2,
  parameter  int unsigned CMP_W    = 2,
  parameter  int unsigned RETIRE_W = 4,
  localparam int unsigned IDX_W    = $clog2(DEPTH)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [ALLOC_W-1:0]               fire_i,
  input  logic [ALLOC_W-1:0][IDX_W-1:0]    alloc_slot_i,
  input  logic [CMP_W-1:0]                 cmp_valid_i,
  input  logic [CMP_W-1:0][IDX_W-1:0]      cmp_tag_i,
  input  logic [CMP_W-1:0]                 cmp_exc_i,
  input  logic [RETIRE_W-1:0]              ret_i,
  input  logic [RETIRE_W-1:0][IDX_W-1:0]   ret_slot_i,
  input  logic                             flush_i,
  output logic [DEPTH-1:0]                 vld_o,
  output logic [DEPTH-1:0]                 done_o,
  output logic [DEPTH-1:0]                 exc_o
);
  logic [DEPTH-1:0] vld_q, done_q, exc_q, vld_d, done_d, exc_d;

  always_comb begin
    vld_d  = vld_q;
    done_d = done_q;
    exc_d  = exc_q;
    // reports to free slots are dropped
    for (int c = 0; c < CMP_W; c++) begin
      if (cmp_valid_i[c] && vld_q[cmp_tag_i[c]]) begin
        done_d[cmp_tag_i[c]] = 1'b1;
        exc_d[cmp_tag_i[c]]  = exc_d[cmp_tag_i[c]] | cmp_exc_i[c];
      end
    end
    for (int r = 0; r < RETIRE_W; r++) begin
      if (ret_i[r]) begin
        vld_d[ret_slot_i[r]]  = 1'b0;
        done_d[ret_slot_i[r]] = 1'b0;
        exc_d[ret_slot_i[r]]  = 1'b0;
      end
    end
    if (flush_i) begin
      vld_d  = '0;
      done_d = '0;
      exc_d  = '0;
    end
    for (int a = 0; a < ALLOC_W; a++) begin
      if (fire_i[a]) begin
        vld_d[alloc_slot_i[a]]  = 1'b1;
        done_d[alloc_slot_i[a]] = 1'b0;
        exc_d[alloc_slot_i[a]]  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      done_q <= '0;
      exc_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      done_q <= done_d;
      exc_q  <= exc_d;
    end
  end

  assign vld_o  = vld_q;
  assign done_o = done_q;
  assign exc_o  = exc_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot_chk
    AST_IDLE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vld_q[i] |-> (!done_q[i] && !exc_q[i])); // R10
  end
  for (genvar c = 0; c < CMP_W; c++) begin : g_cmp_chk
    AST_STRAY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_valid_i[c] && !vld_q[cmp_tag_i[c]]) |=> !done_q[$past(cmp_tag_i[c])]); // R10
  end
  for (genvar a = 0; a < ALLOC_W; a++) begin : g_alloc_chk
    AST_ALLOC_FREE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i[a] |-> !vld_q[alloc_slot_i[a]]); // R11
  end
endmodule

// File: rtl/rob_retire.sv
`timescale 1ns/1ps
module rob_retire #(
  parameter  int unsigned DEPTH    = 16,
  parameter  int unsigned RETIRE_W = 4,
  localparam int unsigned IDX_W    = $clog2(DEPTH),
  localparam int unsigned PTR_W    = IDX_W + 1
) (
  input  logic [PTR_W-1:0]                 head_i,
  input  logic [DEPTH-1:0]                 vld_i,
  input  logic [DEPTH-1:0]                 done_i,
  input  logic [DEPTH-1:0]                 exc_i,
  output logic [RETIRE_W-1:0]              ret_o,
  output logic [RETIRE_W-1:0]              exc_lane_o,
  output logic [RETIRE_W-1:0][IDX_W-1:0]   slot_o,
  output logic [PTR_W-1:0]                 head_nxt_o
);
  always_comb begin
    logic             go;
    logic [PTR_W-1:0] n;
    go         = 1'b1;
    n          = '0;
    ret_o      = '0;
    exc_lane_o = '0;
    for (int k = 0; k < RETIRE_W; k++) begin
      slot_o[k] = IDX_W'(head_i + PTR_W'(k));
      if (go && vld_i[slot_o[k]] && done_i[slot_o[k]]) begin
        ret_o[k] = 1'b1;
        n        = n + PTR_W'(1);
        // a faulting slot ends the group
        if (exc_i[slot_o[k]]) begin
          exc_lane_o[k] = 1'b1;
          go            = 1'b0;
        end
      end else begin
        go = 1'b0;
      end
    end
    head_nxt_o = head_i + n;
  end
endmodule

// File: rtl/rob_core.sv
`timescale 1ns/1ps
module rob_core import rob_pkg::*; #(
  parameter  int unsigned DEPTH    = 16,
  parameter  int unsigned ALLOC_W  = 2,
  parameter  int unsigned RETIRE_W = 4,
  parameter  int unsigned CMP_W    = 2,
  localparam int unsigned IDX_W    = $clog2(DEPTH),
  localparam int unsigned PTR_W    = IDX_W + 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [ALLOC_W-1:0]                alloc_valid_i,
  input  logic [ALLOC_W-1:0][AREG_W-1:0]    alloc_areg_i,
  input  logic [ALLOC_W-1:0][PREG_W-1:0]    alloc_preg_i,
  input  logic [ALLOC_W-1:0]                alloc_store_i,
  input  logic [ALLOC_W-1:0][PC_W-1:0]      alloc_pc_i,
  output logic                              alloc_ready_o,
  output logic [ALLOC_W-1:0][IDX_W-1:0]     alloc_tag_o,
  input  logic [CMP_W-1:0]                  cmp_valid_i,
  input  logic [CMP_W-1:0][IDX_W-1:0]       cmp_tag_i,
  input  logic [CMP_W-1:0]                  cmp_exc_i,
  output logic [RETIRE_W-1:0]               commit_valid_o,
  output logic [RETIRE_W-1:0][AREG_W-1:0]   commit_areg_o,
  output logic [RETIRE_W-1:0][PREG_W-1:0]   commit_preg_o,
  output logic [RETIRE_W-1:0]               store_rel_o,
  output logic                              exc_valid_o,
  output logic [PC_W-1:0]                   exc_pc_o
);
  logic [PTR_W-1:0]                 head_q, head_nxt;
  logic [ALLOC_W-1:0]               fire;
  logic [ALLOC_W-1:0][IDX_W-1:0]    a_slot;
  logic [DEPTH-1:0]                 vld, done, exc;
  logic [RETIRE_W-1:0]              ret, exc_lane;
  logic [RETIRE_W-1:0][IDX_W-1:0]   r_slot;
  logic                             flush;
  rob_meta_t                        meta_q [DEPTH];

  assign flush = |exc_lane;

  rob_alloc #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W)) u_alloc (
    .clk_i, .rst_ni,
    .req_i      (alloc_valid_i),
    .flush_i    (flush),
    .head_i     (head_q),
    .head_nxt_i (head_nxt),
    .ready_o    (alloc_ready_o),
    .fire_o     (fire),
    .slot_o     (a_slot)
  );

  rob_state #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .CMP_W(CMP_W), .RETIRE_W(RETIRE_W)) u_state (
    .clk_i, .rst_ni,
    .fire_i       (fire),
    .alloc_slot_i (a_slot),
    .cmp_valid_i,
    .cmp_tag_i,
    .cmp_exc_i,
    .ret_i        (ret),
    .ret_slot_i   (r_slot),
    .flush_i      (flush),
    .vld_o        (vld),
    .done_o       (done),
    .exc_o        (exc)
  );

  rob_retire #(.DEPTH(DEPTH), .RETIRE_W(RETIRE_W)) u_retire (
    .head_i     (head_q),
    .vld_i      (vld),
    .done_i     (done),
    .exc_i      (exc),
    .ret_o      (ret),
    .exc_lane_o (exc_lane),
    .slot_o     (r_slot),
    .head_nxt_o (head_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) head_q <= '0;
    else         head_q <= head_nxt;
  end

  // payload needs no reset: read only behind a valid slot
  always_ff @(posedge clk_i) begin
    for (int a = 0; a < ALLOC_W; a++) begin
      if (fire[a]) begin
        meta_q[a_slot[a]] <= '{st:   alloc_store_i[a],
                               areg: alloc_areg_i[a],
                               preg: alloc_preg_i[a],
                               pc:   alloc_pc_i[a]};
      end
    end
  end

  assign alloc_tag_o = a_slot;
  assign exc_valid_o = flush;

  always_comb begin
    exc_pc_o = '0;
    for (int k = 0; k < RETIRE_W; k++) begin
      commit_valid_o[k] = ret[k] & ~exc_lane[k];
      commit_areg_o[k]  = meta_q[r_slot[k]].areg;
      commit_preg_o[k]  = meta_q[r_slot[k]].preg;
      store_rel_o[k]    = ret[k] & ~exc_lane[k] & meta_q[r_slot[k]].st;
      if (exc_lane[k]) exc_pc_o = meta_q[r_slot[k]].pc;
    end
  end

  AST_RETIRE_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret & (ret + RETIRE_W'(1))) == '0); // R4
  AST_SINGLE_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(exc_lane)); // R8
  AST_EXC_ENDS_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> (ret == ((exc_lane << 1) - RETIRE_W'(1)))); // R8
  AST_QUIET_AFTER_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |=> (commit_valid_o == '0 && store_rel_o == '0 && !exc_valid_o)); // R9
endmodule

// File: tb/rob_core_tb.sv
`timescale 1ns/1ps
module rob_core_tb;
  import rob_pkg::*;
  localparam int unsigned DEPTH    = 16;
  localparam int unsigned ALLOC_W  = 2;
  localparam int unsigned RETIRE_W = 4;
  localparam int unsigned CMP_W    = 2;
  localparam int unsigned IDX_W    = $clog2(DEPTH);

  logic clk_i  = 1'b0;
  logic rst_ni = 1'b0;
  logic [ALLOC_W-1:0]              alloc_valid_i = '0;
  logic [ALLOC_W-1:0][AREG_W-1:0]  alloc_areg_i  = '0;
  logic [ALLOC_W-1:0][PREG_W-1:0]  alloc_preg_i  = '0;
  logic [ALLOC_W-1:0]              alloc_store_i = '0;
  logic [ALLOC_W-1:0][PC_W-1:0]    alloc_pc_i    = '0;
  logic                            alloc_ready_o;
  logic [ALLOC_W-1:0][IDX_W-1:0]   alloc_tag_o;
  logic [CMP_W-1:0]                cmp_valid_i   = '0;
  logic [CMP_W-1:0][IDX_W-1:0]     cmp_tag_i     = '0;
  logic [CMP_W-1:0]                cmp_exc_i     = '0;
  logic [RETIRE_W-1:0]             commit_valid_o;
  logic [RETIRE_W-1:0][AREG_W-1:0] commit_areg_o;
  logic [RETIRE_W-1:0][PREG_W-1:0] commit_preg_o;
  logic [RETIRE_W-1:0]             store_rel_o;
  logic                            exc_valid_o;
  logic [PC_W-1:0]                 exc_pc_o;

  always #5 clk_i = ~clk_i;

  rob_core #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RETIRE_W(RETIRE_W), .CMP_W(CMP_W)) u_dut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0, seq = 0;
  bit finished = 1'b0;
  int log_areg[$], log_preg[$], log_cyc[$], st_log[$], exc_log[$];

  function automatic int areg_of(int s); return s % 32; endfunction
  function automatic int preg_of(int s); return (s * 3 + 1) % 128; endfunction
  function automatic int pc_of(int s);   return 32'h4000 + s * 4; endfunction

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) if (rst_ni) begin
    for (int k = 0; k < RETIRE_W; k++) begin
      if (commit_valid_o[k]) begin
        log_areg.push_back(int'(commit_areg_o[k]));
        log_preg.push_back(int'(commit_preg_o[k]));
        log_cyc.push_back(cyc);
      end
      if (store_rel_o[k]) st_log.push_back(int'(commit_areg_o[k]));
    end
    if (exc_valid_o) exc_log.push_back(int'(exc_pc_o));
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    log_areg.delete(); log_preg.delete(); log_cyc.delete();
    st_log.delete(); exc_log.delete();
  endtask

  task automatic chk_order(string req, int first, int n);
    int bad = 0;
    for (int i = 0; i < n && i < log_areg.size(); i++) begin
      if (log_areg[i] != areg_of(first + i) || log_preg[i] != preg_of(first + i)) bad++;
    end
    chk(req, "commit order mismatches", bad, 0);
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic set_fields(bit [ALLOC_W-1:0] st);
    for (int k = 0; k < ALLOC_W; k++) begin
      alloc_areg_i[k] = AREG_W'(areg_of(seq + k));
      alloc_preg_i[k] = PREG_W'(preg_of(seq + k));
      alloc_pc_i[k]   = PC_W'(pc_of(seq + k));
    end
    alloc_store_i = st;
  endtask

  task automatic alloc_n(int n, bit [ALLOC_W-1:0] st, output int t0, output int t1, output bit rdy);
    set_fields(st);
    alloc_valid_i = (n == 2) ? 2'b11 : 2'b01;
    #1;
    rdy = alloc_ready_o;
    t0  = int'(alloc_tag_o[0]);
    t1  = int'(alloc_tag_o[1]);
    @(posedge clk_i); #1;
    alloc_valid_i = '0;
    if (rdy) seq += n;
  endtask

  task automatic cmp1(int t, bit e);
    cmp_valid_i = 2'b01; cmp_tag_i[0] = IDX_W'(t); cmp_exc_i = {1'b0, e};
    @(posedge clk_i); #1;
    cmp_valid_i = '0; cmp_exc_i = '0;
  endtask

  task automatic cmp2(int ta, int tb);
    cmp_valid_i = 2'b11; cmp_tag_i[0] = IDX_W'(ta); cmp_tag_i[1] = IDX_W'(tb); cmp_exc_i = '0;
    @(posedge clk_i); #1;
    cmp_valid_i = '0;
  endtask

  task automatic test_reset();
    chk("R2", "ready after reset", int'(alloc_ready_o), 1);
    chk("R4", "no commit after reset", int'(commit_valid_o), 0);
    chk("R6", "no store release after reset", int'(store_rel_o), 0);
    chk("R8", "no exception after reset", int'(exc_valid_o), 0);
    chk("R1", "first tag", int'(alloc_tag_o[0]), 0);
  endtask

  task automatic test_out_of_order();
    int a, b, c, d, s0; bit r;
    s0 = seq;
    alloc_n(2, 2'b00, a, b, r);
    chk("R1", "tag lane0", a, 0); chk("R1", "tag lane1", b, 1);
    alloc_n(2, 2'b00, c, d, r);
    chk("R1", "tag lane0 second group", c, 2); chk("R1", "tag lane1 second group", d, 3);
    clear_logs();
    cmp1(d, 0); cmp1(c, 0); cmp1(b, 0); idle(2);
    chk("R3", "younger completions commit nothing", log_areg.size(), 0);
    cmp1(a, 0); idle(2);
    chk("R4", "commits once head completes", log_areg.size(), 4);
    if (log_cyc.size() == 4) chk("R4", "four retire in one cycle", log_cyc[3] - log_cyc[0], 0);
    chk_order("R5", s0, 4);
  endtask

  task automatic test_width();
    int t[6]; int s0; bit r;
    s0 = seq;
    for (int i = 0; i < 3; i++) alloc_n(2, 2'b00, t[2*i], t[2*i+1], r);
    clear_logs();
    cmp2(t[4], t[5]); cmp2(t[2], t[3]); cmp2(t[0], t[1]); idle(3);
    chk("R4", "six commits", log_areg.size(), 6);
    if (log_cyc.size() == 6) begin
      chk("R4", "first group in one cycle", log_cyc[3] - log_cyc[0], 0);
      chk("R4", "overflow lanes next cycle", log_cyc[4] - log_cyc[0], 1);
    end
    chk_order("R5", s0, 6);
  endtask

  task automatic test_store();
    int a, b, s0; bit r;
    s0 = seq;
    alloc_n(2, 2'b01, a, b, r);
    clear_logs();
    cmp2(a, b); idle(3);
    chk("R6", "one store strobe", st_log.size(), 1);
    if (st_log.size() > 0) chk("R6", "strobe on store slot", st_log[0], areg_of(s0));
    chk("R6", "both commit", log_areg.size(), 2);
  endtask

  task automatic test_full();
    int a, b, s0; bit r;
    s0 = seq;
    clear_logs();
    alloc_n(1, 2'b00, a, b, r);
    for (int i = 0; i < 7; i++) alloc_n(2, 2'b00, a, b, r);
    chk("R2", "ready low with one free slot", int'(alloc_ready_o), 0);
    cmp1(s0 % DEPTH, 0); idle(2);
    chk("R2", "ready back with two free", int'(alloc_ready_o), 1);
    alloc_n(2, 2'b00, a, b, r);
    chk("R1", "wrapped tag lane0", a, (s0 + 15) % DEPTH);
    chk("R1", "wrapped tag lane1", b, (s0 + 16) % DEPTH);
    chk("R7", "ready low when full", int'(alloc_ready_o), 0);
    alloc_n(2, 2'b00, a, b, r);
    chk("R7", "request while full refused", int'(r), 0);
    for (int s = s0 + 16; s > s0; s -= 2) cmp2(s % DEPTH, (s - 1) % DEPTH);
    idle(6);
    chk("R7", "each accepted slot retires once", log_areg.size(), 17);
    chk_order("R7", s0, 17);
    chk("R7", "ready after drain", int'(alloc_ready_o), 1);
  endtask

  task automatic test_exception();
    int ta, tb, tc, td, s0, n0; bit r;
    s0 = seq;
    alloc_n(2, 2'b10, ta, tb, r);
    alloc_n(2, 2'b00, tc, td, r);
    clear_logs();
    cmp1(tb, 1); cmp2(tc, td); idle(2);
    chk("R8", "no exception at completion", exc_log.size(), 0);
    chk("R8", "nothing commits before head", log_areg.size(), 0);
    cmp1(ta, 0); idle(3);
    chk("R8", "older slot commits", log_areg.size(), 1);
    if (log_areg.size() > 0) chk("R8", "older slot areg", log_areg[0], areg_of(s0));
    chk("R8", "single exception pulse", exc_log.size(), 1);
    if (exc_log.size() > 0) chk("R8", "exception pc", exc_log[0], pc_of(s0 + 1));
    chk("R8", "faulting store not released", st_log.size(), 0);
    chk("R9", "ready after flush", int'(alloc_ready_o), 1);
    seq = s0 + 4;
    n0 = seq;
    alloc_n(1, 2'b00, ta, tb, r);
    chk("R9", "tag after faulting slot", ta, (tb + 0 == tb) ? (s0 + 2) % DEPTH : 0);
    cmp1(ta, 0); idle(3);
    chk("R9", "younger flushed, new slot commits", log_areg.size(), 2);
    if (log_areg.size() > 1) chk("R9", "new slot areg", log_areg[1], areg_of(n0));
  endtask

  task automatic test_stray();
    int a, b, c, d; bit r;
    cmp1((seq + 2) % DEPTH, 1);
    alloc_n(2, 2'b00, a, b, r);
    alloc_n(1, 2'b00, c, d, r);
    clear_logs();
    cmp2(a, b); idle(3);
    chk("R10", "stray report left slot incomplete", log_areg.size(), 2);
    cmp1(c, 0); idle(3);
    chk("R10", "slot retires after own report", log_areg.size(), 3);
    chk("R10", "stray exception flag ignored", exc_log.size(), 0);
  endtask

  task automatic test_concurrent();
    int pend[$]; int s0;
    s0 = seq;
    clear_logs();
    for (int i = 0; i < 30; i++) begin
      bit a_on; int t0, t1;
      a_on = (i % 5 != 4) && alloc_ready_o;
      set_fields(2'b00);
      alloc_valid_i = a_on ? 2'b11 : 2'b00;
      if (i % 7 != 6 && pend.size() >= 2) begin
        cmp_valid_i  = 2'b11;
        cmp_tag_i[0] = IDX_W'(pend.pop_front());
        cmp_tag_i[1] = IDX_W'(pend.pop_front());
      end
      #1;
      t0 = int'(alloc_tag_o[0]); t1 = int'(alloc_tag_o[1]);
      @(posedge clk_i); #1;
      alloc_valid_i = '0; cmp_valid_i = '0;
      if (a_on) begin pend.push_back(t0); pend.push_back(t1); seq += 2; end
    end
    while (pend.size() >= 2) cmp2(pend.pop_front(), pend.pop_front());
    while (pend.size() > 0) cmp1(pend.pop_front(), 0);
    idle(5);
    chk("R11", "commits equal accepted", log_areg.size(), seq - s0);
    chk_order("R11", s0, seq - s0);
    chk("R11", "ready after stream", int'(alloc_ready_o), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    idle(1);
    test_reset();
    test_out_of_order();
    test_width();
    test_store();
    test_full();
    test_exception();
    test_stray();
    test_concurrent();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule